// File: doc/BRIEF.md
# Transmit Buffer Add-Request Register

This block holds the host's add requests for a bank of transmit buffers. The host writes a word in which each 1 asks for one buffer to be queued for transmission. The block turns those requests into a per-buffer pending vector for a transmit scan engine. It also sends the engine a one-cycle start pulse, so that the engine evaluates the pending buffers again.

Requests are accepted only for buffers below the configured buffer count. A request for a buffer that is already pending is dropped. When the scan engine is idle, a request moves into the pending vector on the clock edge that captures the write. While a scan is running, requests stay in the register, where the host can read them back. They move to pending when the engine signals that the scan has finished. A transmission-complete pulse for a buffer clears that buffer's pending bit.

Top module: `tx_add_req`

## Requirements
- R1: After reset, `pending`, `rd_data` and `scan_start` are all zero.
- R2: A `wr_en` cycle sets the request for each bit of `wr_data` that is 1. A 0 bit has no effect, and a write of all zeros changes neither the requests nor `pending`.
- R3: Bit i is accepted only when i < `buf_count`. Bits at or above the count are ignored, and their `pending` and request bits stay 0.
- R4: A request for a buffer whose `pending` bit is set is dropped. It is neither recorded nor re-transferred.
- R5: With `scan_busy` low and `scan_done` low, accepted bits appear in `pending` one cycle after the write. `scan_start` is 1 for exactly that one cycle, and `rd_data` reads 0.
- R6: While `scan_busy` is high and `scan_done` is low, accepted bits stay in the request register and are visible on `rd_data`. `pending` does not change except through `tx_done`, and `scan_start` stays 0.
- R7: In a cycle with `scan_done` high, the held requests move to `pending` and `scan_start` pulses in the next cycle, provided at least one request was held.
- R8: A write in the same cycle as `scan_done` is not lost. Its bits stay in the request register and move to `pending` at the next transfer.
- R9: A `tx_done[i]` pulse clears `pending[i]` on the next edge.
- R10: When `tx_done[i]` and an idle-time write of bit i occur in the same cycle, `pending[i]` is set afterwards.
- R11: `rd_data` returns the held request bits, with every bit at or above `buf_count` reading 0.
- R12: Lowering `buf_count` clears the request and `pending` bits of buffers that are no longer configured, so they are never transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | NBUF | Add-request word (1 = request) |
| rd_data | output | NBUF | Held request bits, masked to the configured buffers |
| buf_count | input | CNT_W | Number of configured buffers |
| scan_busy | input | 1 | Scan engine is running |
| scan_done | input | 1 | Scan engine finished (one cycle) |
| tx_done | input | NBUF | Per-buffer transmission-complete pulses |
| pending | output | NBUF | Pending transmission requests |
| scan_start | output | 1 | One-cycle pulse after a transfer into pending |

## Verification
The bench builds the block with NBUF = 8 and CNT_W = 4. At that size a single byte of stimulus reaches every bit, including the top bit that only a full buffer count configures. The small count lets the bench step the buffer count between 8, 4 and 2 and watch bits above the limit vanish from both the request register and pending. These settings also bring within reach the collisions that matter: a write landing on the done cycle, and a completion on the same buffer as a new request.

// File: rtl/tx_add_req.sv
module tx_add_req #(
  parameter int NBUF  = 32,
  parameter int CNT_W = $clog2(NBUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBUF-1:0]  wr_data,
  output logic [NBUF-1:0]  rd_data,
  input  logic [CNT_W-1:0] buf_count,
  input  logic             scan_busy,
  input  logic             scan_done,
  input  logic [NBUF-1:0]  tx_done,
  output logic [NBUF-1:0]  pending,
  output logic             scan_start
);

  logic [NBUF-1:0] cfg, req, fresh, moved, req_nx;

  for (genvar i = 0; i < NBUF; i++) begin : g_cfg
    assign cfg[i] = buf_count > CNT_W'(i);
  end

  assign fresh = wr_en ? (wr_data & cfg & ~(pending & ~tx_done)) : '0;

  always_comb begin
    if (scan_done) begin
      moved  = req & cfg;
      req_nx = fresh;
    end else if (scan_busy) begin
      moved  = '0;
      req_nx = (req | fresh) & cfg;
    end else begin
      moved  = (req | fresh) & cfg;
      req_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req        <= '0;
      pending    <= '0;
      scan_start <= 1'b0;
    end else begin
      req        <= req_nx;
      pending    <= ((pending & ~tx_done) | moved) & cfg;
      scan_start <= |moved;
    end
  end

  assign rd_data = req & cfg;

endmodule

// File: rtl/tx_add_req_chk.sv
module tx_add_req_chk #(
  parameter int NBUF  = 32,
  parameter int CNT_W = $clog2(NBUF + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [NBUF-1:0]  wr_data,
  input logic [CNT_W-1:0] buf_count,
  input logic             scan_busy,
  input logic             scan_done,
  input logic [NBUF-1:0]  pending,
  input logic             scan_start
);

  logic [NBUF-1:0] lim;
  for (genvar i = 0; i < NBUF; i++) begin : g_lim
    assign lim[i] = buf_count > CNT_W'(i);
  end

  // R5
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_busy && !scan_done && wr_en && |(wr_data & lim & ~pending)) |=> scan_start);

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_busy && !scan_done) |=> !scan_start);

  // R7
  start_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> |pending);

  // R4
  rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(pending & ~$past(pending)) |-> scan_start);

  // R3
  stable_count_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(buf_count) |-> ((pending & ~lim) == '0));

endmodule

bind tx_add_req tx_add_req_chk #(.NBUF(NBUF), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .buf_count(buf_count), .scan_busy(scan_busy), .scan_done(scan_done),
  .pending(pending), .scan_start(scan_start)
);

// File: tb/test_tx_add_req.sv
module test_tx_add_req;
  localparam int NB = 8;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, scan_busy = 1'b0, scan_done = 1'b0;
  logic [NB-1:0] wr_data = '0, tx_done = '0;
  logic [CW-1:0] buf_count = 4'd8;
  logic [NB-1:0] rd_data, pending;
  logic scan_start;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tx_add_req #(.NBUF(NB), .CNT_W(CW)) i_tx_add_req (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .buf_count(buf_count), .scan_busy(scan_busy), .scan_done(scan_done),
    .tx_done(tx_done), .pending(pending), .scan_start(scan_start));

  typedef struct packed {
    logic [3:0] cnt; logic busy; logic done; logic we;
    logic [7:0] wd; logic [7:0] txd;
    logic [7:0] e_pend; logic [7:0] e_rd; logic e_start; logic [3:0] tag;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'd8,1'b0,1'b0,1'b1,8'h05,8'h00,8'h05,8'h00,1'b1,4'd5},   // R5 R2
    '{4'd8,1'b0,1'b0,1'b0,8'h00,8'h00,8'h05,8'h00,1'b0,4'd5},   // R5 pulse ends
    '{4'd8,1'b0,1'b0,1'b1,8'h06,8'h00,8'h07,8'h00,1'b1,4'd4},   // R4 bit2 pending
    '{4'd8,1'b0,1'b0,1'b0,8'h00,8'h04,8'h03,8'h00,1'b0,4'd9},   // R9
    '{4'd8,1'b1,1'b0,1'b1,8'h30,8'h00,8'h03,8'h30,1'b0,4'd6},   // R6
    '{4'd8,1'b1,1'b0,1'b1,8'h40,8'h00,8'h03,8'h70,1'b0,4'd6},   // R6 merge
    '{4'd8,1'b1,1'b1,1'b1,8'h80,8'h00,8'h73,8'h80,1'b1,4'd7},   // R7 R8
    '{4'd8,1'b0,1'b0,1'b0,8'h00,8'h00,8'hF3,8'h00,1'b1,4'd8},   // R8
    '{4'd4,1'b0,1'b0,1'b1,8'h0C,8'h00,8'h0F,8'h00,1'b1,4'd12},  // R12
    '{4'd4,1'b0,1'b0,1'b1,8'hF0,8'h00,8'h0F,8'h00,1'b0,4'd3},   // R3
    '{4'd4,1'b0,1'b0,1'b1,8'h01,8'h01,8'h0F,8'h00,1'b1,4'd10},  // R10
    '{4'd8,1'b1,1'b0,1'b1,8'h80,8'h00,8'h0F,8'h80,1'b0,4'd6},   // R6
    '{4'd2,1'b1,1'b0,1'b0,8'h00,8'h00,8'h03,8'h00,1'b0,4'd11},  // R11 R12
    '{4'd8,1'b1,1'b1,1'b0,8'h00,8'h00,8'h03,8'h00,1'b0,4'd12},  // R12 nothing moves
    '{4'd8,1'b0,1'b0,1'b0,8'h00,8'h03,8'h00,8'h00,1'b0,4'd9},   // R9
    '{4'd8,1'b0,1'b0,1'b1,8'h00,8'h00,8'h00,8'h00,1'b0,4'd2}    // R2 zero write
  };

  task automatic check(input string tag, input logic [NB-1:0] ep, input logic [NB-1:0] er,
                       input logic es);
    total++;
    if (pending !== ep || rd_data !== er || scan_start !== es) begin
      bad++;
      $display("FAIL %s: pending=%h rd=%h start=%b expected pending=%h rd=%h start=%b",
               tag, pending, rd_data, scan_start, ep, er, es);
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    foreach (VECS[k]) begin
      buf_count = VECS[k].cnt; scan_busy = VECS[k].busy; scan_done = VECS[k].done;
      wr_en = VECS[k].we; wr_data = VECS[k].wd; tx_done = VECS[k].txd;
      @(negedge clk);
      check($sformatf("vec%0d R%0d", k, VECS[k].tag), VECS[k].e_pend, VECS[k].e_rd, VECS[k].e_start);
    end
    wr_en = 1'b0; tx_done = '0; scan_done = 1'b0;

    // R11: bits written above count while busy never read back
    buf_count = 4'd3; scan_busy = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 masked read", 8'h00, 8'h07, 1'b0);
    // R7: done transfers held bits, start pulses once
    scan_done = 1'b1;
    @(negedge clk);
    scan_done = 1'b0; scan_busy = 1'b0;
    check("R7 transfer", 8'h07, 8'h00, 1'b1);
    @(negedge clk);
    check("R7 single pulse", 8'h07, 8'h00, 1'b0);
    // R1: reset mid-operation clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    buf_count = 4'd8; wr_en = 1'b1; wr_data = 8'h80;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3 top bit at full count", 8'h80, 8'h00, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule